// File: doc/BRIEF.md
# Pulse-Swallow Gate Controller

This block drives the active-low swallow enable of a dual-modulus prescaler inside a frequency-synthesis loop. It runs on the prescaler clock. A reference-rate pulse arrives once per output period. On each such pulse the block opens a swallow window that lasts `10 - N` clock cycles, where `N` is a decimal preset from 0 to 9. During the window the enable is held low. A larger preset therefore swallows fewer prescaler pulses per period.

A fractional request input lets a rate multiplier remove one swallowed pulse from a single period. The block captures each request and holds it as a pending credit. The credit shortens the next window by one cycle and is used up when that window starts.

The reference pulse and the fractional request are asynchronous to the clock. Each passes through two flip-flop stages and is then edge-detected, so a level held high counts as a single event.

Top module: `swallow_gate`

## Requirements
- R1: An active-high synchronous reset `srst` drives `swallow_n` high and discards any pending fractional credit. After reset, a window with preset N lasts the full 10-N cycles.
- R2: A rising edge on `ref_pulse` is first sampled at clock edge E0. `swallow_n` then goes low after clock edge E2. It never goes low without such an edge.
- R3: When no credit is pending, `swallow_n` stays low for exactly 10-N consecutive cycles, for N from 0 to 9.
- R4: A preset above 9 behaves as 9, giving a window of one cycle.
- R5: When a credit is pending at the start of a window, that window lasts 9-N cycles.
- R6: With N of 9 (or more) and a pending credit, no window opens and `swallow_n` stays high for that period.
- R7: A request that arrives after a window has started does not change that window. It is applied to the next window only, and one request shortens exactly one window.
- R8: A request first sampled on the same clock edge as the reference pulse applies to the window that pulse opens.
- R9: A new reference edge during an open window restarts the window from the preset. `swallow_n` stays low throughout, and the window ends 10-N cycles after the restart.
- R10: `preset_n` is sampled only when a window starts. Changing it during the window has no effect on that window's length.
- R11: A `ref_pulse` level held high for many cycles opens a single window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler clock |
| srst | input | 1 | Synchronous reset, active high |
| ref_pulse | input | 1 | Reference-rate pulse, asynchronous |
| frac_req | input | 1 | Fractional request (remove one swallow), asynchronous |
| preset_n | input | 4 | Decimal preset N; values above 9 are treated as 9 |
| swallow_n | output | 1 | Swallow enable to the prescaler, active low |

## Verification
The start of a window and the capture of a fractional request can fall in the same cycle. In that cycle the request must be consumed by the window that is starting, not left pending. The bench provokes this by raising `ref_pulse` and `frac_req` together, both in directed cases and in random iterations. It judges the result by the measured low time (9-N, or no window at all when N is 9). It also judges it by the next window coming back to the full 10-N. A second overlap, a reference edge during an open window, is judged by the total unbroken low time.

// File: rtl/swallow_gate.sv
module swallow_gate #(
  parameter int CW   = 4,
  parameter int TERM = 9
) (
  input  logic          clk,
  input  logic          srst,
  input  logic          ref_pulse,
  input  logic          frac_req,
  input  logic [CW-1:0] preset_n,
  output logic          swallow_n
);
  localparam logic [CW-1:0] TERM_V = CW'(TERM);

  logic [2:0]    ref_sh, frac_sh;
  logic [CW-1:0] cnt;
  logic          pend;

  wire           load  = ref_sh[1] & ~ref_sh[2];
  wire           fedge = frac_sh[1] & ~frac_sh[2];
  wire [CW-1:0]  n_cl  = (preset_n > TERM_V) ? TERM_V : preset_n;
  wire [CW-1:0]  start = n_cl + CW'(pend | fedge);

  always_ff @(posedge clk) begin
    if (srst) begin
      ref_sh  <= '0;
      frac_sh <= '0;
    end else begin
      ref_sh  <= {ref_sh[1:0], ref_pulse};
      frac_sh <= {frac_sh[1:0], frac_req};
    end
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      cnt       <= '0;
      pend      <= 1'b0;
      swallow_n <= 1'b1;
    end else if (load) begin
      cnt       <= start;
      pend      <= 1'b0;
      swallow_n <= (start > TERM_V);
    end else begin
      if (fedge) pend <= 1'b1;
      if (!swallow_n) begin
        if (cnt == TERM_V) swallow_n <= 1'b1;
        else               cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

module swallow_gate_chk #(
  parameter int CW   = 4,
  parameter int TERM = 9
) (
  input logic          clk,
  input logic          srst,
  input logic          load,
  input logic          fedge,
  input logic          pend,
  input logic          swallow_n,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] preset_n
);
  localparam logic [CW-1:0] TERM_V = CW'(TERM);
  localparam logic [CW-1:0] SKIP_V = CW'(TERM + 1);

  assert_reset_R1: assert property (@(posedge clk)
    srst |=> (swallow_n && !pend));

  assert_open_R2: assert property (@(posedge clk) disable iff (srst)
    (load && !pend && !fedge) |=> !swallow_n);

  assert_idle_R2: assert property (@(posedge clk) disable iff (srst)
    (swallow_n && !load) |=> swallow_n);

  assert_step_R3: assert property (@(posedge clk) disable iff (srst)
    (!swallow_n && cnt != TERM_V && !load) |=> (!swallow_n && cnt == CW'($past(cnt) + 1'b1)));

  assert_close_R3: assert property (@(posedge clk) disable iff (srst)
    (!swallow_n && cnt == TERM_V && !load) |=> swallow_n);

  assert_range_R4: assert property (@(posedge clk) disable iff (srst)
    cnt <= SKIP_V);

  assert_skip_R6: assert property (@(posedge clk) disable iff (srst)
    (load && (pend || fedge) && preset_n >= TERM_V) |=> swallow_n);

  assert_single_use_R7: assert property (@(posedge clk) disable iff (srst)
    load |=> !pend);
endmodule

bind swallow_gate swallow_gate_chk #(.CW(CW), .TERM(TERM)) chk_i (
  .clk(clk), .srst(srst), .load(load), .fedge(fedge), .pend(pend),
  .swallow_n(swallow_n), .cnt(cnt), .preset_n(preset_n)
);

// File: tb/swallow_gate_tb.sv
module swallow_gate_tb_top;
  logic       clk = 1'b0;
  logic       srst = 1'b1;
  logic       ref_pulse = 1'b0;
  logic       frac_req = 1'b0;
  logic [3:0] preset_n = 4'd0;
  logic       swallow_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  swallow_gate dut_i (
    .clk(clk), .srst(srst), .ref_pulse(ref_pulse),
    .frac_req(frac_req), .preset_n(preset_n), .swallow_n(swallow_n)
  );

  function automatic int exp_len(int n, int f);
    int c = (n > 9) ? 9 : n;
    int l = 10 - c - f;
    return (l < 0) ? 0 : l;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input int n, input int n2, input int frac_at, input int hold,
                     input int ref2, output int first, output int len);
    first = 0;
    len   = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i >= 1 && !swallow_n) begin
        if (first == 0) first = i;
        len++;
      end
      preset_n  = 4'((i >= 5) ? n2 : n);
      ref_pulse = (i < hold) || (i == ref2);
      frac_req  = (i == frac_at);
    end
    ref_pulse = 1'b0;
    frac_req  = 1'b0;
  endtask

  task automatic frac_pulse();
    @(negedge clk) frac_req = 1'b1;
    @(negedge clk) frac_req = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int f, l, n, m;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset high", int'(swallow_n), 1);
    srst = 1'b0;
    repeat (3) @(negedge clk);

    // R2 / R3: timing and length for every preset
    for (int k = 0; k <= 9; k++) begin
      run(k, k, -1, 1, -1, f, l);
      check($sformatf("R2 start N=%0d", k), f, 3);
      check($sformatf("R3 len N=%0d", k), l, exp_len(k, 0));
    end
    run(13, 13, -1, 1, -1, f, l);
    check("R4 clamp N=13", l, 1);
    run(15, 15, -1, 1, -1, f, l);
    check("R4 clamp N=15", l, 1);

    frac_pulse();
    run(4, 4, -1, 1, -1, f, l);
    check("R5 pending credit N=4", l, 5);
    frac_pulse();
    run(0, 0, -1, 1, -1, f, l);
    check("R5 pending credit N=0", l, 9);

    frac_pulse();
    run(9, 9, -1, 1, -1, f, l);
    check("R6 no window N=9", l, 0);
    run(9, 9, 0, 1, -1, f, l);
    check("R6 no window coincident", l, 0);

    run(0, 0, 5, 1, -1, f, l);
    check("R7 late request ignored now", l, 10);
    run(0, 0, -1, 1, -1, f, l);
    check("R7 applied to next window", l, 9);
    run(0, 0, -1, 1, -1, f, l);
    check("R7 used once", l, 10);

    run(3, 3, 0, 1, -1, f, l);
    check("R8 coincident request", l, 6);
    run(3, 3, -1, 1, -1, f, l);
    check("R8 not left pending", l, 7);

    run(0, 0, -1, 1, 5, f, l);
    check("R9 restart start", f, 3);
    check("R9 restart len", l, 15);

    run(2, 8, -1, 1, -1, f, l);
    check("R10 preset change mid-window", l, 8);

    run(3, 3, -1, 20, -1, f, l);
    check("R11 held ref single window", l, 7);

    frac_pulse();
    @(negedge clk) srst = 1'b1;
    @(negedge clk) srst = 1'b0;
    check("R1 reset releases", int'(swallow_n), 1);
    repeat (3) @(negedge clk);
    run(5, 5, -1, 1, -1, f, l);
    check("R1 credit cleared by reset", l, 5);

    for (int it = 0; it < 60; it++) begin
      n = $urandom_range(0, 15);
      m = $urandom_range(0, 2);
      if (m == 1) frac_pulse();
      run(n, n, (m == 2) ? 0 : -1, 1, -1, f, l);
      check($sformatf("R3/R5/R8 random N=%0d mode=%0d", n, m), l, exp_len(n, (m != 0) ? 1 : 0));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule